// File: doc/BRIEF.md
# Instruction-Cycle Interrupt Controller with Sleep Wake-Up

This block holds the interrupt control and flag register of a small 8-bit core whose instruction cycle is split into four phases, Q1 to Q4. It collects four sources: an external pin with a selectable active edge, a timer rollover pulse, a port-change pulse and a level request from peripherals. Each of the first three sets a sticky flag that only software clears. A flag combined with its own enable forms a pending request.

When the core is awake, the controller samples the pending request at every Q1. If the global enable is set, it takes the interrupt. It clears the global enable so that the handler is not re-entered. It lets the current instruction finish and marks two dummy instruction cycles. Then it raises a one-clock fetch request that carries the vector address. While the core sleeps, any individually enabled pending source raises a wake signal whatever the global enable holds. Once the core is awake again, the global enable alone decides whether it vectors.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: The control register reads and writes as one byte, MSB first: bit 7 global enable, bit 6 peripheral enable, bit 5 timer enable, bit 4 pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 pin flag, bit 0 port-change flag.
- R2: With `edge_rise` = 1, a low-to-high transition on `ext_pin` sets the pin flag and a falling one does not. With `edge_rise` = 0 the roles swap.
- R3: A detected pin edge sets the pin flag only at a clock edge where `phase` is Q4 (3) or Q1 (0). An edge detected in Q2 (1) or Q3 (2) is held until the next such phase. Phase codes are Q1=0, Q2=1, Q3=2, Q4=3.
- R4: Hardware never clears a flag. A flag set event in the same cycle as a software write that clears the flag leaves the flag set.
- R5: A one-clock `tmr_ovf` pulse sets the timer flag (bit 2).
- R6: A one-clock `port_chg` pulse sets the port-change flag (bit 0).
- R7: The pending request is the OR of each flag ANDed with its enable, plus `periph_req` ANDed with the peripheral enable. A flag whose enable is clear, or `periph_req` while bit 6 is clear, neither wakes the core nor dispatches.
- R8: While `sleeping` is high, `wake` is high one clock after a request becomes pending, regardless of the global enable. It falls one clock after the request is no longer pending.
- R9: At a clock edge where `phase` is Q1, a request is pending, the global enable is set and `sleeping` is low, the dispatch is accepted and the global enable reads 0 afterwards. `dummy_cyc` is then high for 8 clocks (two instruction cycles). `vec_fetch` is high for one clock, 12 clocks after the accepting edge, with `vec_addr` = 0x0004.
- R10: With the global enable clear, or while `sleeping` is high, no dispatch starts.
- R11: The asynchronous `rst_n` clears the whole register. A synchronous `warm_rst` clears bits 7 to 1, keeps bit 0, and cancels a dispatch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per Q phase |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous non-power-on reset |
| phase | input | 2 | Current phase, Q1=0 to Q4=3 |
| sleeping | input | 1 | Core is in sleep |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_rise | input | 1 | 1 selects the rising edge, 0 the falling edge |
| tmr_ovf | input | 1 | Timer rollover pulse |
| port_chg | input | 1 | Port-change event pulse |
| periph_req | input | 1 | Level request from peripheral flags |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register contents |
| wake | output | 1 | Wake request while sleeping |
| dummy_cyc | output | 1 | High during the dummy instruction cycles |
| vec_fetch | output | 1 | One-clock fetch request at the vector |
| vec_addr | output | 13 | Vector address while `vec_fetch` is high, else 0 |

## Verification
A corrupted flag or enable bit shows on `reg_rdata` in the clock after the edge that stored it. It also shows on `wake` one clock later, or as a missing or spurious `dummy_cyc` at the next Q1. An error in the dispatch sequencer's state or counter moves the `vec_fetch` pulse away from the twelfth clock after the global enable falls, so it is visible within three instruction cycles. A wrong edge-detector state shows as a pin flag that is missing, set by the wrong edge, or set in Q2 or Q3, within two instruction cycles of the pin change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    // Bit order is visible to software and must stay as is.
    typedef struct packed {
        logic glb_en;
        logic per_en;
        logic tmr_en;
        logic pin_en;
        logic chg_en;
        logic tmr_flg;
        logic pin_flg;
        logic chg_flg;
    } ctl_reg_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FINISH = 2'd1,
        SQ_DUMMY  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/irqc_pin_edge.sv
module irqc_pin_edge
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst,
    input  logic [1:0] phase,
    input  logic       ext_pin,
    input  logic       edge_rise,
    output logic       set_o
);
    localparam int SW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] chain;
        logic          pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic rising, falling, hit, in_win;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SW-2:0], ext_pin};
        rising     = st_q.chain[SW-2] & ~st_q.chain[SW-1];
        falling    = ~st_q.chain[SW-2] & st_q.chain[SW-1];
        hit        = edge_rise ? rising : falling;
        in_win     = (phase == PH_Q4) || (phase == PH_Q1);
        set_o      = (hit | st_q.pend) & in_win;
        st_d.pend  = (hit | st_q.pend) & ~in_win;
        if (warm_rst) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a held edge is released as soon as the window opens
    a_r3_pend_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !warm_rst && ((phase == PH_Q4) || (phase == PH_Q1))) |=> !st_q.pend);

endmodule

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       set_tmr,
    input  logic       set_pin,
    input  logic       set_chg,
    input  logic       clr_glb,
    output ctl_reg_t   reg_o
);
    ctl_reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (we) begin
            reg_d = ctl_reg_t'(wdata);
        end
        // sources win over a software clear in the same cycle
        if (set_tmr) reg_d.tmr_flg = 1'b1;
        if (set_pin) reg_d.pin_flg = 1'b1;
        if (set_chg) reg_d.chg_flg = 1'b1;
        if (clr_glb) reg_d.glb_en  = 1'b0;
        if (warm_rst) begin
            reg_d         = '0;
            reg_d.chg_flg = reg_q.chg_flg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign reg_o = reg_q;

    // R4: a flag only falls through a software write or a warm reset
    a_r4_pin_flag_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_q.pin_flg) |-> ($past(we && !wdata[1]) || $past(warm_rst)));
    a_r4_tmr_flag_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_q.tmr_flg) |-> ($past(we && !wdata[2]) || $past(warm_rst)));
    // R11: warm reset leaves only the port-change flag
    a_r11_warm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (reg_q[7:1] == 7'd0));

endmodule

// File: rtl/irqc_sequencer.sv
module irqc_sequencer
    import irqc_pkg::*;
#(
    parameter int DUMMY_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst,
    input  logic [1:0] phase,
    input  logic       pend,
    input  logic       glb_en,
    input  logic       sleeping,
    output logic       accept_o,
    output logic       dummy_o,
    output logic       fetch_o
);
    localparam int CW = $clog2(DUMMY_CYCLES + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          fetch;
    } seq_st_t;

    seq_st_t sq_d, sq_q;
    logic at_q1;

    always_comb begin
        sq_d       = sq_q;
        sq_d.fetch = 1'b0;
        at_q1      = (phase == PH_Q1);
        accept_o   = (sq_q.state == SQ_IDLE) && at_q1 && pend && glb_en
                     && !sleeping && !warm_rst;
        case (sq_q.state)
            SQ_IDLE: begin
                if (accept_o) begin
                    sq_d.state = SQ_FINISH;
                end
            end
            SQ_FINISH: begin
                if (at_q1) begin
                    sq_d.state = SQ_DUMMY;
                    sq_d.cnt   = '0;
                end
            end
            SQ_DUMMY: begin
                if (at_q1) begin
                    if (sq_q.cnt == CW'(DUMMY_CYCLES - 1)) begin
                        sq_d.state = SQ_IDLE;
                        sq_d.fetch = 1'b1;
                    end else begin
                        sq_d.cnt = sq_q.cnt + 1'b1;
                    end
                end
            end
            default: sq_d.state = SQ_IDLE;
        endcase
        if (warm_rst) begin
            sq_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign dummy_o = (sq_q.state == SQ_DUMMY);
    assign fetch_o = sq_q.fetch;

    // R9: dummy cycles and the fetch pulse are aligned to Q1 boundaries
    a_r9_dummy_starts_at_q1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dummy_o) |-> ($past(phase) == PH_Q1));
    a_r9_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> !fetch_o);

endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
    import irqc_pkg::*;
#(
    parameter int              SYNC_STAGES  = 2,
    parameter int              DUMMY_CYCLES = 2,
    parameter int              ADDR_W       = 13,
    parameter logic [ADDR_W-1:0] VEC_ADDR   = 'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic [1:0]        phase,
    input  logic              sleeping,
    input  logic              ext_pin,
    input  logic              edge_rise,
    input  logic              tmr_ovf,
    input  logic              port_chg,
    input  logic              periph_req,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              wake,
    output logic              dummy_cyc,
    output logic              vec_fetch,
    output logic [ADDR_W-1:0] vec_addr
);
    ctl_reg_t ctl;
    logic pin_set, accept, pend;
    logic wake_d, wake_q;

    irqc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_rst (warm_rst),
        .phase    (phase),
        .ext_pin  (ext_pin),
        .edge_rise(edge_rise),
        .set_o    (pin_set)
    );

    irqc_ctrl_reg reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .warm_rst(warm_rst),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .set_tmr (tmr_ovf),
        .set_pin (pin_set),
        .set_chg (port_chg),
        .clr_glb (accept),
        .reg_o   (ctl)
    );

    irqc_sequencer #(.DUMMY_CYCLES(DUMMY_CYCLES)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .warm_rst(warm_rst),
        .phase   (phase),
        .pend    (pend),
        .glb_en  (ctl.glb_en),
        .sleeping(sleeping),
        .accept_o(accept),
        .dummy_o (dummy_cyc),
        .fetch_o (vec_fetch)
    );

    always_comb begin
        pend   = (ctl.tmr_flg & ctl.tmr_en) | (ctl.pin_flg & ctl.pin_en)
               | (ctl.chg_flg & ctl.chg_en) | (periph_req & ctl.per_en);
        wake_d = sleeping & pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= wake_d;
        end
    end

    assign wake      = wake_q;
    assign reg_rdata = ctl;
    assign vec_addr  = vec_fetch ? VEC_ADDR : '0;

    // R3: the pin flag rises only after a Q4 or Q1 edge, or by software
    a_r3_pin_flag_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.pin_flg) |-> (($past(phase) == PH_Q4) || ($past(phase) == PH_Q1)
                                || $past(reg_we && reg_wdata[1])));
    // R8: enabled pin flag while asleep raises wake on the next clock
    a_r8_pin_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && ctl.pin_en && ctl.pin_flg) |=> wake);
    // R9: accepting a dispatch drops the global enable
    a_r9_glb_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ctl.glb_en);
    // R9: the fetch pulse follows the last dummy cycle
    a_r9_fetch_after_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch |-> $past(dummy_cyc));
    // R10: no dispatch begins while asleep
    a_r10_none_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !sleeping);

endmodule

// File: tb/irq_dispatch_ctrl_tb_top.sv
module irq_dispatch_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic [1:0]  phase = 2'd0;
    logic        sleeping = 1'b0;
    logic        ext_pin = 1'b0;
    logic        edge_rise = 1'b1;
    logic        tmr_ovf = 1'b0;
    logic        port_chg = 1'b0;
    logic        periph_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        wake, dummy_cyc, vec_fetch;
    logic [12:0] vec_addr;

    int checks = 0;
    int errors = 0;

    irq_dispatch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .phase(phase),
        .sleeping(sleeping), .ext_pin(ext_pin), .edge_rise(edge_rise),
        .tmr_ovf(tmr_ovf), .port_chg(port_chg), .periph_req(periph_req),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake(wake), .dummy_cyc(dummy_cyc), .vec_fetch(vec_fetch),
        .vec_addr(vec_addr)
    );

    initial forever #4 clk = ~clk;
    initial forever @(negedge clk) phase <= phase + 2'd1;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic no_dispatch(input int n, input string req);
        int seen = 0;
        repeat (n) begin
            tick(1);
            if (dummy_cyc || vec_fetch) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    // waits for the global enable to fall, then times the sequence
    task automatic measure(input string req);
        int n = 0;
        int nd = 0;
        int w = 0;
        while (reg_rdata[7] && w < 10) begin
            tick(1);
            w++;
        end
        chk(!reg_rdata[7], {req, " glb cleared"}, reg_rdata[7], 0);
        while (!vec_fetch && n < 20) begin
            tick(1);
            n++;
            if (dummy_cyc) nd++;
        end
        chk(n == 12, {req, " latency"}, n, 12);
        chk(nd == 8, {req, " dummy clocks"}, nd, 8);
        chk(vec_addr == 13'h0004, {req, " vector"}, vec_addr, 4);
    endtask

    task automatic t_reset();
        tick(3);
        chk(reg_rdata == 8'h00, "R11 por reg", reg_rdata, 0);
        chk(!wake && !dummy_cyc && !vec_fetch, "R11 por outputs",
            {wake, dummy_cyc, vec_fetch}, 0);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_rw();
        wr(8'h5A);
        chk(reg_rdata == 8'h5A, "R1 readback", reg_rdata, 8'h5A);
        wr(8'h00);
        chk(reg_rdata == 8'h00, "R1 clear", reg_rdata, 0);
    endtask

    task automatic t_edges();
        edge_rise = 1'b1; ext_pin = 1'b1; tick(10);
        chk(reg_rdata[1], "R2 rising sets", reg_rdata[1], 1);
        wr(8'h00); ext_pin = 1'b0; tick(10);
        chk(!reg_rdata[1], "R2 falling ignored", reg_rdata[1], 0);
        edge_rise = 1'b0; ext_pin = 1'b1; tick(10);
        chk(!reg_rdata[1], "R2 rising ignored", reg_rdata[1], 0);
        ext_pin = 1'b0; tick(10);
        chk(reg_rdata[1], "R2 falling sets", reg_rdata[1], 1);
        edge_rise = 1'b1;
    endtask

    task automatic t_window();
        for (int off = 0; off < 4; off++) begin
            logic [1:0] ph;
            int w = 0;
            wr(8'h00);
            tick(off);
            ext_pin = 1'b1;
            ph = 2'd1;
            while (w < 12) begin
                @(posedge clk);
                ph = phase;
                #2;
                w++;
                if (reg_rdata[1]) break;
            end
            chk(reg_rdata[1] && (ph == 2'd3 || ph == 2'd0), "R3 window", ph, 0);
            ext_pin = 1'b0;
            tick(6);
        end
    endtask

    task automatic t_sticky();
        wr(8'h12);
        tick(20);
        chk(reg_rdata == 8'h12, "R4 flag kept", reg_rdata, 8'h12);
        reg_we = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        tick(1);
        reg_we = 1'b0; tmr_ovf = 1'b0;
        chk(reg_rdata == 8'h04, "R4 set beats clear", reg_rdata, 8'h04);
    endtask

    task automatic t_sources();
        wr(8'h00);
        tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
        chk(reg_rdata == 8'h04, "R5 timer flag", reg_rdata, 8'h04);
        wr(8'h00);
        port_chg = 1'b1; tick(1); port_chg = 1'b0;
        chk(reg_rdata == 8'h01, "R6 change flag", reg_rdata, 8'h01);
    endtask

    task automatic t_wake();
        sleeping = 1'b1;
        wr(8'h12); tick(2);
        chk(wake, "R8 wake pin", wake, 1);
        wr(8'h02); tick(2);
        chk(!wake, "R7 flag without enable", wake, 0);
        wr(8'h00); periph_req = 1'b1; tick(2);
        chk(!wake, "R7 periph gated", wake, 0);
        wr(8'h40); tick(2);
        chk(wake, "R7 periph enabled", wake, 1);
        periph_req = 1'b0; wr(8'h00); tick(2);
        chk(!wake, "R8 wake falls", wake, 0);
        sleeping = 1'b0;
    endtask

    task automatic t_dispatch();
        wr(8'h12);
        no_dispatch(16, "R10 glb clear");
        sleeping = 1'b1;
        wr(8'h92);
        no_dispatch(16, "R10 asleep");
        chk(wake, "R8 wake with glb", wake, 1);
        sleeping = 1'b0;
        measure("R9 pin");
        chk(reg_rdata == 8'h12, "R4 flag after dispatch", reg_rdata, 8'h12);
        no_dispatch(16, "R10 no reentry");
        wr(8'h84);
        no_dispatch(16, "R7 timer gated");
        wr(8'hA4);
        measure("R9 timer");
    endtask

    task automatic t_warm();
        wr(8'h7F);
        warm_rst = 1'b1; tick(1); warm_rst = 1'b0;
        chk(reg_rdata == 8'h01, "R11 warm keeps bit0", reg_rdata, 1);
        wr(8'h7E);
        warm_rst = 1'b1; tick(1); warm_rst = 1'b0;
        chk(reg_rdata == 8'h00, "R11 warm clears", reg_rdata, 0);
        wr(8'hA4);
        while (reg_rdata[7]) tick(1);
        tick(5);
        warm_rst = 1'b1; tick(1); warm_rst = 1'b0;
        no_dispatch(16, "R11 warm cancels");
    endtask

    initial begin
        t_reset();
        t_rw();
        t_edges();
        t_window();
        t_sticky();
        t_sources();
        t_wake();
        t_dispatch();
        t_warm();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule